// File: doc/BRIEF.md
# Two-Operand Arctangent Special-Value Resolver

This block is the front stage of a single-precision two-operand arctangent unit. Each cycle it may accept a pair of binary32 operands, y (numerator) and x (denominator). It classifies each operand as zero, finite non-zero, infinite or NaN. Where those classes alone fix the answer, it produces the final binary32 result and raises a bypass flag. The result is then either a propagated NaN or a multiple of pi (0, pi/4, pi/2, 3pi/4, pi) that takes the sign of y.

When no special rule applies, bypass stays low and the core arctangent datapath downstream uses the forwarded operands. The block does no arithmetic. One register stage separates the inputs from every output. A signalling NaN is returned in quiet form, and an invalid-operation indication goes with it.

The rules are tried in a fixed order and the first match wins. NaN operands come first, with x ahead of y. Infinite operands come next, and zero operands last. Subnormal operands count as finite and non-zero.

Top module: `a2sv_atan2_special`

## Requirements
- R1: out_valid equals in_valid delayed by one clock. On a cycle with in_valid high, y_out and x_out take the accepted operands one cycle later. On a cycle with in_valid low, bypass, invalid, result, y_out and x_out keep their values. After reset every output is zero.
- R2: If x is a NaN (exponent field all ones, mantissa non-zero), bypass is 1. The result is x with mantissa bit 22 forced to 1. This rule takes priority over every rule that tests y.
- R3: If x is not a NaN and y is a NaN, bypass is 1 and the result is y with mantissa bit 22 forced to 1.
- R4: If x is +infinity and y is infinite, the result is 0x3F490FDB (pi/4) with bit 31 replaced by the sign of y. If x is +infinity and y is finite, the result is zero with the sign of y.
- R5: If x is -infinity and y is infinite, the result is 0x4016CBE4 (3pi/4) with the sign of y. If x is -infinity and y is finite, the result is 0x40490FDB (pi) with the sign of y.
- R6: If x is finite and y is infinite, the result is 0x3FC90FDB (pi/2) with the sign of y.
- R7: If x is zero of either sign and y is finite non-zero, the result is pi/2 with the sign of y.
- R8: If y is zero and x is finite, the result depends on bit 31 of x. When that bit is clear (+0 or positive), the result is zero with the sign of y. When it is set (-0 or negative), the result is pi with the sign of y.
- R9: If none of R2 to R8 applies, bypass is 0 and the result is 0x00000000.
- R10: invalid is 1 exactly when at least one accepted operand is a signalling NaN (a NaN with mantissa bit 22 clear), including when the other operand's NaN is the one returned.
- R11: A subnormal operand (exponent field zero, mantissa non-zero) is treated as finite and non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| y | input | 32 | Numerator operand, binary32 |
| x | input | 32 | Denominator operand, binary32 |
| out_valid | output | 1 | Registered copy of in_valid |
| bypass | output | 1 | Result is final; core evaluation not needed |
| result | output | 32 | Final binary32 value when bypass is 1, else zero |
| invalid | output | 1 | A signalling NaN operand was seen |
| y_out | output | 32 | Registered y for the core datapath |
| x_out | output | 32 | Registered x for the core datapath |

## Verification
A wrong operand class or a misordered rule appears in the cycle right after the operands are accepted. It shows as a result word with the wrong magnitude constant or the wrong sign, or as a bypass flag that disagrees with the operand classes. A corrupted held register shows on the first idle cycle, as a changed output while in_valid is low. Sweeping every pairing of representative operands covers each rule boundary in both priority directions: zeros, subnormals, normals, both infinities, and quiet and signalling NaNs of both signs.

// File: rtl/a2sv_pkg.sv
package a2sv_pkg;

    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int WORD_W = 1 + EXP_W + MAN_W;
    localparam int QBIT   = MAN_W - 1;

    localparam logic [WORD_W-1:0] K_PI_QTR  = 32'h3F49_0FDB;
    localparam logic [WORD_W-1:0] K_PI_HALF = 32'h3FC9_0FDB;
    localparam logic [WORD_W-1:0] K_PI_3QTR = 32'h4016_CBE4;
    localparam logic [WORD_W-1:0] K_PI_FULL = 32'h4049_0FDB;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_FIN,
        CLS_INF,
        CLS_NAN
    } opcls_e;

    typedef struct packed {
        opcls_e cls;
        logic   sgn;
        logic   snan;
    } opinfo_t;

    typedef enum logic [3:0] {
        RULE_NONE,
        RULE_XNAN,
        RULE_YNAN,
        RULE_PINF_YINF,
        RULE_PINF_YFIN,
        RULE_NINF_YINF,
        RULE_NINF_YFIN,
        RULE_YINF,
        RULE_XZERO,
        RULE_YZERO_XPOS,
        RULE_YZERO_XNEG
    } rule_e;

    typedef struct packed {
        logic              vld;
        logic              byp;
        logic              nv;
        logic [WORD_W-1:0] res;
        logic [WORD_W-1:0] yv;
        logic [WORD_W-1:0] xv;
    } stage_t;

endpackage

// File: rtl/a2sv_opclass.sv
module a2sv_opclass
    import a2sv_pkg::*;
#(
    parameter int E_W = EXP_W,
    parameter int M_W = MAN_W
) (
    input  logic [E_W+M_W:0] op,
    output opinfo_t          info
);
    localparam int TOP = E_W + M_W;

    logic [E_W-1:0] exp_f;
    logic [M_W-1:0] man_f;
    logic           exp_ones;
    logic           exp_none;
    logic           man_none;

    always_comb begin
        exp_f    = op[TOP-1 -: E_W];
        man_f    = op[M_W-1:0];
        exp_ones = &exp_f;
        exp_none = ~|exp_f;
        man_none = ~|man_f;

        info.sgn  = op[TOP];
        info.snan = 1'b0;
        if (exp_ones && !man_none) begin
            info.cls  = CLS_NAN;
            info.snan = ~man_f[M_W-1];
        end else if (exp_ones) begin
            info.cls = CLS_INF;
        end else if (exp_none && man_none) begin
            info.cls = CLS_ZERO;
        end else begin
            info.cls = CLS_FIN;
        end
    end
endmodule

// File: rtl/a2sv_rule_pick.sv
module a2sv_rule_pick
    import a2sv_pkg::*;
(
    input  opinfo_t           yi,
    input  opinfo_t           xi,
    input  logic [WORD_W-1:0] y,
    input  logic [WORD_W-1:0] x,
    output logic              byp,
    output logic              nv,
    output logic [WORD_W-1:0] res
);
    rule_e             rule;
    logic              x_fin;
    logic              y_fin;
    logic [WORD_W-1:0] mag;
    logic [WORD_W-1:0] qmask;

    always_comb begin
        x_fin = (xi.cls == CLS_ZERO) || (xi.cls == CLS_FIN);
        y_fin = (yi.cls == CLS_ZERO) || (yi.cls == CLS_FIN);

        // priority chain: NaN, then infinities, then zeros
        if (xi.cls == CLS_NAN)                       rule = RULE_XNAN;
        else if (yi.cls == CLS_NAN)                  rule = RULE_YNAN;
        else if (xi.cls == CLS_INF && !xi.sgn)       rule = y_fin ? RULE_PINF_YFIN : RULE_PINF_YINF;
        else if (xi.cls == CLS_INF)                  rule = y_fin ? RULE_NINF_YFIN : RULE_NINF_YINF;
        else if (yi.cls == CLS_INF)                  rule = RULE_YINF;
        else if (xi.cls == CLS_ZERO && yi.cls == CLS_FIN) rule = RULE_XZERO;
        else if (yi.cls == CLS_ZERO && x_fin)        rule = xi.sgn ? RULE_YZERO_XNEG : RULE_YZERO_XPOS;
        else                                         rule = RULE_NONE;
    end

    always_comb begin
        qmask = '0;
        qmask[QBIT] = 1'b1;
        unique case (rule)
            RULE_XNAN:       mag = x | qmask;
            RULE_YNAN:       mag = y | qmask;
            RULE_PINF_YINF:  mag = K_PI_QTR;
            RULE_NINF_YINF:  mag = K_PI_3QTR;
            RULE_NINF_YFIN,
            RULE_YZERO_XNEG: mag = K_PI_FULL;
            RULE_YINF,
            RULE_XZERO:      mag = K_PI_HALF;
            default:         mag = '0;
        endcase

        byp = (rule != RULE_NONE);
        nv  = xi.snan | yi.snan;
        res = mag;
        if (byp && rule != RULE_XNAN && rule != RULE_YNAN) begin
            res[WORD_W-1] = yi.sgn;
        end
    end
endmodule

// File: rtl/a2sv_atan2_special.sv
module a2sv_atan2_special
    import a2sv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] y,
    input  logic [31:0] x,
    output logic        out_valid,
    output logic        bypass,
    output logic [31:0] result,
    output logic        invalid,
    output logic [31:0] y_out,
    output logic [31:0] x_out
);
    opinfo_t           y_info;
    opinfo_t           x_info;
    logic              pick_byp;
    logic              pick_nv;
    logic [WORD_W-1:0] pick_res;
    stage_t            st_d;
    stage_t            st_q;

    a2sv_opclass u_cls_y (.op(y), .info(y_info));
    a2sv_opclass u_cls_x (.op(x), .info(x_info));

    a2sv_rule_pick u_pick (
        .yi  (y_info),
        .xi  (x_info),
        .y   (y),
        .x   (x),
        .byp (pick_byp),
        .nv  (pick_nv),
        .res (pick_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.byp = pick_byp;
            st_d.nv  = pick_nv;
            st_d.res = pick_res;
            st_d.yv  = y;
            st_d.xv  = x;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign bypass    = st_q.byp;
    assign invalid   = st_q.nv;
    assign result    = st_q.res;
    assign y_out     = st_q.yv;
    assign x_out     = st_q.xv;

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid)); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(y_out) && $stable(bypass)); // R1

    AST_XNAN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && x_info.cls == CLS_NAN |=> bypass && result == ($past(x) | 32'h0040_0000)); // R2

    AST_SIGN_FROM_Y: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && x_info.cls != CLS_NAN && y_info.cls != CLS_NAN
        |=> !bypass || result[31] == $past(y[31])); // R4

    AST_FINITE_PAIR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && x_info.cls == CLS_FIN && y_info.cls == CLS_FIN
        |=> !bypass && result == 32'h0); // R9

    AST_FLAG_ON_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> bypass && (&result[30:23]) && result[22]); // R10
endmodule

// File: tb/a2sv_atan2_special_tb.sv
module a2sv_atan2_special_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] y = '0;
    logic [31:0] x = '0;
    logic        out_valid, bypass, invalid;
    logic [31:0] result, y_out, x_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    a2sv_atan2_special u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .y(y), .x(x),
        .out_valid(out_valid), .bypass(bypass), .result(result),
        .invalid(invalid), .y_out(y_out), .x_out(x_out)
    );

    function automatic logic [31:0] sample_val(input int i);
        case (i)
            0:  return 32'h0000_0000;
            1:  return 32'h8000_0000;
            2:  return 32'h0000_0001;
            3:  return 32'h807F_FFFF;
            4:  return 32'h3F80_0000;
            5:  return 32'hC020_0000;
            6:  return 32'h7F7F_FFFF;
            7:  return 32'h8080_0000;
            8:  return 32'h7F80_0000;
            9:  return 32'hFF80_0000;
            10: return 32'h7FC0_0001;
            11: return 32'hFFC1_2345;
            12: return 32'h7F80_0001;
            default: return 32'hFFA0_0000;
        endcase
    endfunction

    function automatic bit f_nan(input logic [31:0] v);
        return v[30:23] == 8'hFF && v[22:0] != 0;
    endfunction
    function automatic bit f_inf(input logic [31:0] v);
        return v[30:0] == 31'h7F80_0000;
    endfunction
    function automatic bit f_zero(input logic [31:0] v);
        return v[30:0] == 0;
    endfunction
    function automatic bit f_sub(input logic [31:0] v);
        return v[30:23] == 0 && v[22:0] != 0;
    endfunction

    task automatic expect_of(input logic [31:0] vy, input logic [31:0] vx,
                             output logic [31:0] r, output bit b, output string tag);
        logic [31:0] s;
        s = {vy[31], 31'h0};
        b = 1'b1;
        if (f_nan(vx))                       begin r = vx | 32'h0040_0000; tag = "R2"; end
        else if (f_nan(vy))                  begin r = vy | 32'h0040_0000; tag = "R3"; end
        else if (vx == 32'h7F80_0000)        begin r = f_inf(vy) ? (s | 32'h3F49_0FDB) : s; tag = "R4"; end
        else if (vx == 32'hFF80_0000)        begin r = s | (f_inf(vy) ? 32'h4016_CBE4 : 32'h4049_0FDB); tag = "R5"; end
        else if (f_inf(vy))                  begin r = s | 32'h3FC9_0FDB; tag = "R6"; end
        else if (f_zero(vx) && !f_zero(vy))  begin r = s | 32'h3FC9_0FDB; tag = (f_sub(vy)) ? "R11" : "R7"; end
        else if (f_zero(vy))                 begin r = vx[31] ? (s | 32'h4049_0FDB) : s; tag = "R8"; end
        else begin
            r = 32'h0; b = 1'b0;
            tag = (f_sub(vx) || f_sub(vy)) ? "R11" : "R9";
        end
    endtask

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (y=%h x=%h)", tag, act, exp_v, y, x);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] er;
        bit          eb;
        string       tg;
        logic [31:0] hold_r, hold_y;
        repeat (3) @(negedge clk);
        // R1 reset state
        check32("R1", {31'h0, out_valid}, 32'h0);
        check32("R1", result, 32'h0);
        check32("R1", {30'h0, bypass, invalid}, 32'h0);
        check32("R1", y_out | x_out, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int iy = 0; iy < 14; iy++) begin
            for (int ix = 0; ix < 14; ix++) begin
                y = sample_val(iy);
                x = sample_val(ix);
                in_valid = 1'b1;
                @(negedge clk);
                expect_of(y, x, er, eb, tg);
                check32(tg, result, er);
                check32(tg, {31'h0, bypass}, {31'h0, eb});
                check32("R10", {31'h0, invalid},
                        {31'h0, (f_nan(y) && !y[22]) || (f_nan(x) && !x[22])});
                check32("R1", {31'h0, out_valid}, 32'h1);
                check32("R1", y_out, y);
                check32("R1", x_out, x);
            end
        end
        // R1 idle: outputs hold while in_valid low
        hold_r = result;
        hold_y = y_out;
        in_valid = 1'b0;
        y = 32'h3F80_0000;
        x = 32'h7FC0_0000;
        @(negedge clk);
        check32("R1", {31'h0, out_valid}, 32'h0);
        check32("R1", result, hold_r);
        check32("R1", y_out, hold_y);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule